// File: doc/BRIEF.md
# PHY Tuning Bit-Serial Write Engine

This block writes tuning values into the configuration space of one of several analog PHYs. All PHYs share one 16-bit control word: an 8-bit address field, a single serial data bit and one strobe bit per PHY. A value of L bits goes out one bit per step. Each bit lands at its own address, starting at the requested address and counting up. The least significant bit goes first. For every bit the engine sets the address and data, raises the strobe of the selected PHY and then lowers it.

A requester issues a direct write with a PHY index, start address, data word and length. It then waits on busy and done. A second input runs the fixed power-up tuning sequence for one PHY. The engine accepts one command at a time. It ignores any command that arrives while it is busy, so several requesters sharing it are serialized.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset the control word is all zero and busy, done and err are low.
- R2: In the control word, bits [15:8] carry the address and bit 7 carries the data bit. The strobe of PHY n is bit 2n. Every other bit is zero.
- R3: A direct write of length L (1 to 8) gives exactly L strobe pulses on the selected PHY. Pulse i carries address start+i (modulo 256) and data bit i, so the LSB goes first.
- R4: Each bit runs in three phases: a setup phase with the strobe low, a high phase, then a low phase. Each phase lasts P = max(phase_cycles,1) cycles. Address and data hold still from setup until the strobe has fallen.
- R5: At most one strobe bit is high at any time. A start seen while busy is ignored. When both start inputs are high in the same idle cycle, the power-up sequence wins.
- R6: done is a one-cycle pulse. Busy is high from the cycle after acceptance until done. No strobe is high while the engine is not busy.
- R7: A direct write with length 0, or with a PHY index at or above the PHY count, pulses done with err in the cycle after acceptance. It raises no strobe.
- R8: The power-up sequence for PHY 0 writes three values in this order: 1 bit of value 1 at 0x0C, then 5 bits of 0x14 at 0x20, then 2 bits of the disconnect threshold input at 0x2A.
- R9: The power-up sequence for any other PHY leaves out the 0x0C write and does the other two writes in the same order.
- R10: A power-up request naming a PHY at or above the PHY count ends with done and err and raises no strobe.
- R11: A direct write of L bits raises done exactly 3·P·L clock edges after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phy_count | input | 2 | Number of PHYs present (2 or 3) |
| cfg_disc_thresh | input | 2 | Disconnect threshold written by the power-up sequence |
| cfg_phase_cycles | input | 4 | Cycles per strobe phase (0 is treated as 1) |
| req_start | input | 1 | Start a direct write |
| req_phy | input | 2 | Target PHY of a direct write |
| req_addr | input | 8 | Start address |
| req_data | input | 8 | Data word, sent LSB first |
| req_len | input | 4 | Number of bits to send |
| seq_start | input | 1 | Start the power-up sequence |
| seq_phy | input | 2 | Target PHY of the power-up sequence |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Valid with done: the command was rejected |
| ctl_word | output | 16 | Shared control word driven to the PHYs |

## Verification
The assertions assume the configuration inputs stay constant while a command runs. They also assume the PHY count never exceeds the number of strobe positions. The bench only changes cfg_phy_count, cfg_disc_thresh and cfg_phase_cycles between commands, while the engine is idle, and keeps the count at 2 or 3. Start pulses given during a busy window are there on purpose, to show they are ignored. They are never used to change the configuration.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 4;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LOAD  = 3'd1,
        S_SETUP = 3'd2,
        S_HIGH  = 3'd3,
        S_HOLD  = 3'd4,
        S_DONE  = 3'd5
    } wr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  len;
    } tune_write_t;
endpackage

// File: rtl/phy_tune_seq_rom.sv
module phy_tune_seq_rom
    import phy_tune_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CAL_ADDR   = 8'h0C,
    parameter logic [ADDR_W-1:0] AMP_ADDR   = 8'h20,
    parameter logic [DATA_W-1:0] AMP_VALUE  = 8'h14,
    parameter int                AMP_BITS   = 5,
    parameter logic [ADDR_W-1:0] DISC_ADDR  = 8'h2A,
    parameter int                DISC_BITS  = 2
) (
    input  logic [1:0]  step,
    input  logic [1:0]  disc_thresh,
    output tune_write_t wr
);
    always_comb begin
        wr = '0;
        case (step)
            2'd0: begin
                wr.addr = CAL_ADDR;
                wr.data = DATA_W'(1);
                wr.len  = LEN_W'(1);
            end
            2'd1: begin
                wr.addr = AMP_ADDR;
                wr.data = AMP_VALUE;
                wr.len  = LEN_W'(AMP_BITS);
            end
            default: begin
                wr.addr = DISC_ADDR;
                wr.data = DATA_W'(disc_thresh);
                wr.len  = LEN_W'(DISC_BITS);
            end
        endcase
    end
endmodule

// File: rtl/phy_tune_ctl_pack.sv
module phy_tune_ctl_pack
    import phy_tune_pkg::*;
#(
    parameter int MAX_PHYS = 3,
    parameter int PHY_W    = 2,
    parameter int CTL_W    = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bit_val,
    input  logic              stb_en,
    input  logic [PHY_W-1:0]  phy,
    output logic [CTL_W-1:0]  ctl
);
    logic [MAX_PHYS-1:0] sel;

    for (genvar g = 0; g < MAX_PHYS; g++) begin : g_sel
        assign sel[g] = stb_en && (phy == PHY_W'(g));
    end

    always_comb begin
        ctl = '0;
        ctl[CTL_W-1 -: ADDR_W] = addr;
        ctl[7] = bit_val;
        for (int n = 0; n < MAX_PHYS; n++) begin
            ctl[2*n] = sel[n];
        end
    end
endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
    import phy_tune_pkg::*;
#(
    parameter int MAX_PHYS = 3,
    parameter int PH_W     = 4,
    parameter int CTL_W    = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(MAX_PHYS+1)-1:0]     cfg_phy_count,
    input  logic [1:0]                        cfg_disc_thresh,
    input  logic [PH_W-1:0]                   cfg_phase_cycles,
    input  logic                              req_start,
    input  logic [$clog2(MAX_PHYS)-1:0]       req_phy,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [DATA_W-1:0]                 req_data,
    input  logic [LEN_W-1:0]                  req_len,
    input  logic                              seq_start,
    input  logic [$clog2(MAX_PHYS)-1:0]       seq_phy,
    output logic                              busy,
    output logic                              done,
    output logic                              err,
    output logic [CTL_W-1:0]                  ctl_word
);
    localparam int PHY_W     = $clog2(MAX_PHYS);
    localparam logic [1:0] LAST_STEP = 2'd2;

    typedef struct packed {
        wr_state_e         st;
        logic [PHY_W-1:0]  phy;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  left;
        logic [PH_W-1:0]   tmr;
        logic              seq;
        logic [1:0]        step;
        logic              stb;
        logic              err;
    } eng_t;

    eng_t        q, d;
    tune_write_t rom_wr;
    logic [PH_W-1:0] reload;

    assign reload = (cfg_phase_cycles == '0) ? '0 : cfg_phase_cycles - 1'b1;

    phy_tune_seq_rom u_rom (
        .step        (q.step),
        .disc_thresh (cfg_disc_thresh),
        .wr          (rom_wr)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                d.err = 1'b0;
                d.seq = 1'b0;
                if (seq_start) begin
                    if (int'(seq_phy) >= int'(cfg_phy_count)) begin
                        d.err = 1'b1;
                        d.st  = S_DONE;
                    end else begin
                        d.phy  = seq_phy;
                        d.seq  = 1'b1;
                        d.step = (seq_phy == '0) ? 2'd0 : 2'd1;
                        d.st   = S_LOAD;
                    end
                end else if (req_start) begin
                    if (req_len == '0 || int'(req_phy) >= int'(cfg_phy_count)) begin
                        d.err = 1'b1;
                        d.st  = S_DONE;
                    end else begin
                        d.phy  = req_phy;
                        d.addr = req_addr;
                        d.data = req_data;
                        d.left = req_len;
                        d.tmr  = reload;
                        d.st   = S_SETUP;
                    end
                end
            end
            S_LOAD: begin
                d.addr = rom_wr.addr;
                d.data = rom_wr.data;
                d.left = rom_wr.len;
                d.tmr  = reload;
                d.st   = S_SETUP;
            end
            S_SETUP: begin
                if (q.tmr == '0) begin
                    d.stb = 1'b1;
                    d.tmr = reload;
                    d.st  = S_HIGH;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            S_HIGH: begin
                if (q.tmr == '0) begin
                    d.stb = 1'b0;
                    d.tmr = reload;
                    d.st  = S_HOLD;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            S_HOLD: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (q.left == LEN_W'(1)) begin
                    d.left = '0;
                    if (q.seq && q.step != LAST_STEP) begin
                        d.step = q.step + 2'd1;
                        d.st   = S_LOAD;
                    end else begin
                        d.st = S_DONE;
                    end
                end else begin
                    d.left = q.left - 1'b1;
                    d.addr = q.addr + 1'b1;
                    d.data = q.data >> 1;
                    d.tmr  = reload;
                    d.st   = S_SETUP;
                end
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: begin
                d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != S_IDLE);
    assign done = (q.st == S_DONE);
    assign err  = done && q.err;

    phy_tune_ctl_pack #(
        .MAX_PHYS (MAX_PHYS),
        .PHY_W    (PHY_W),
        .CTL_W    (CTL_W)
    ) u_pack (
        .addr    (q.addr),
        .bit_val (q.data[0]),
        .stb_en  (q.stb),
        .phy     (q.phy),
        .ctl     (ctl_word)
    );
endmodule

// File: rtl/phy_tune_writer_chk.sv
module phy_tune_writer_chk #(
    parameter int MAX_PHYS = 3,
    parameter int CTL_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [CTL_W-1:0] ctl_word
);
    logic [MAX_PHYS-1:0] stbs;
    logic [6:0]          spare;

    always_comb begin
        spare = ctl_word[6:0];
        for (int n = 0; n < MAX_PHYS; n++) begin
            stbs[n]      = ctl_word[2*n];
            spare[2*n]   = 1'b0;
        end
    end

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        spare == '0);                                                   // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stbs));                                                // R5
    AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|stbs) |-> $stable(ctl_word[15:7]));                           // R4
    AST_FALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|stbs) |-> $stable(ctl_word[15:7]));                      // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (stbs == '0));                                        // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && stbs == '0));                                  // R7
endmodule

bind phy_tune_writer phy_tune_writer_chk #(
    .MAX_PHYS (MAX_PHYS),
    .CTL_W    (CTL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .ctl_word (ctl_word)
);

// File: tb/phy_tune_writer_test.sv
module phy_tune_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_phy_count = 2'd3;
    logic [1:0]  cfg_disc_thresh = 2'd3;
    logic [3:0]  cfg_phase_cycles = 4'd1;
    logic        req_start = 1'b0;
    logic [1:0]  req_phy = '0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [3:0]  req_len = '0;
    logic        seq_start = 1'b0;
    logic [1:0]  seq_phy = '0;
    logic        busy, done, err;
    logic [15:0] ctl_word;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    phy_tune_writer uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_phy_count(cfg_phy_count), .cfg_disc_thresh(cfg_disc_thresh),
        .cfg_phase_cycles(cfg_phase_cycles),
        .req_start(req_start), .req_phy(req_phy), .req_addr(req_addr),
        .req_data(req_data), .req_len(req_len),
        .seq_start(seq_start), .seq_phy(seq_phy),
        .busy(busy), .done(done), .err(err), .ctl_word(ctl_word)
    );

    // pulse monitor
    logic [15:0] prev_ctl = '0;
    int          mon_n = 0;
    int          width = 0;
    logic [7:0]  mon_addr [0:63];
    logic        mon_bit  [0:63];
    logic [6:0]  mon_stb  [0:63];
    int          mon_w    [0:63];
    logic        mon_setup[0:63];

    function automatic logic any_stb(input logic [15:0] c);
        return c[0] | c[2] | c[4];
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (any_stb(ctl_word) && !any_stb(prev_ctl)) begin
                if (mon_n < 64) begin
                    mon_addr[mon_n]  = ctl_word[15:8];
                    mon_bit[mon_n]   = ctl_word[7];
                    mon_stb[mon_n]   = ctl_word[6:0];
                    mon_setup[mon_n] = (ctl_word[15:7] == prev_ctl[15:7]);
                    mon_w[mon_n]     = 0;
                end
                mon_n = mon_n + 1;
                width = 1;
            end else if (any_stb(ctl_word)) begin
                width = width + 1;
            end else if (any_stb(prev_ctl) && mon_n > 0 && mon_n <= 64) begin
                mon_w[mon_n-1] = width;
            end
        end
        prev_ctl = ctl_word;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // expected pulse list
    logic [7:0] exp_a [0:63];
    logic       exp_b [0:63];
    int         exp_n;

    task automatic add_exp(input logic [7:0] a, input logic [7:0] v, input int len);
        for (int i = 0; i < len; i++) begin
            exp_a[exp_n] = a + 8'(i);
            exp_b[exp_n] = v[i];
            exp_n++;
        end
    endtask

    task automatic cmp_pulses(input int phy, input int p, input string tag);
        chk(mon_n == exp_n, {tag, " pulse count"}, mon_n, exp_n);
        for (int i = 0; i < exp_n && i < mon_n; i++) begin
            chk(mon_addr[i] == exp_a[i], {tag, " R3 address"}, mon_addr[i], exp_a[i]);
            chk(mon_bit[i] == exp_b[i], {tag, " R3 data bit"}, mon_bit[i], exp_b[i]);
            chk(mon_stb[i] == 7'(1 << (2*phy)), {tag, " R2 strobe position"},
                mon_stb[i], 1 << (2*phy));
            chk(mon_w[i] == p, {tag, " R4 high width"}, mon_w[i], p);
            chk(mon_setup[i], {tag, " R4 setup before rise"}, 0, 1);
        end
    endtask

    task automatic wait_done(output int cnt);
        cnt = 0;
        forever begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (done || cnt > 2000) break;
        end
    endtask

    task automatic do_write(input int phy, input logic [7:0] a, input logic [7:0] v,
                            input int len, input logic poke);
        int cnt;
        int p;
        p = (cfg_phase_cycles == 0) ? 1 : int'(cfg_phase_cycles);
        mon_n = 0;
        exp_n = 0;
        add_exp(a, v, len);
        @(negedge clk);
        req_phy = 2'(phy); req_addr = a; req_data = v; req_len = 4'(len);
        req_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_start = 1'b0;
        chk(busy == 1'b1, "R6 busy after accept", busy, 1);
        if (poke) begin
            req_phy = 2'((phy + 1) % 3); req_addr = 8'h55; req_len = 4'd3;
            req_start = 1'b1; seq_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0; seq_start = 1'b0;
        end
        wait_done(cnt);
        if (poke) cnt = cnt + 1;
        chk(done == 1'b1, "R6 done seen", done, 1);
        chk(err == 1'b0, "R7 no err on valid write", err, 0);
        chk(cnt == 3 * p * len, "R11 write duration", cnt, 3 * p * len);
        @(negedge clk);
        chk(done == 1'b0, "R6 done single cycle", done, 0);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R5 idle after one command", busy, 0);
        cmp_pulses(phy, p, poke ? "R5 ignore-while-busy" : "R3 direct");
    endtask

    task automatic do_reject(input int phy, input int len, input logic is_seq, input string tag);
        mon_n = 0;
        @(negedge clk);
        if (is_seq) begin
            seq_phy = 2'(phy); seq_start = 1'b1;
        end else begin
            req_phy = 2'(phy); req_len = 4'(len); req_addr = 8'h10; req_start = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        seq_start = 1'b0; req_start = 1'b0;
        chk(done == 1'b1, {tag, " done"}, done, 1);
        chk(err == 1'b1, {tag, " err"}, err, 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {tag, " back to idle"}, busy, 0);
        chk(mon_n == 0, {tag, " no strobe"}, mon_n, 0);
    endtask

    task automatic do_seq(input int phy, input logic with_req);
        int cnt;
        int p;
        p = (cfg_phase_cycles == 0) ? 1 : int'(cfg_phase_cycles);
        mon_n = 0;
        exp_n = 0;
        if (phy == 0) add_exp(8'h0C, 8'h01, 1);
        add_exp(8'h20, 8'h14, 5);
        add_exp(8'h2A, {6'd0, cfg_disc_thresh}, 2);
        @(negedge clk);
        seq_phy = 2'(phy); seq_start = 1'b1;
        if (with_req) begin
            req_phy = 2'd1; req_addr = 8'h77; req_data = 8'hFF; req_len = 4'd4;
            req_start = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        seq_start = 1'b0; req_start = 1'b0;
        wait_done(cnt);
        chk(done == 1'b1 && err == 1'b0, "R8 sequence completes cleanly", err, 0);
        cmp_pulses(phy, p, phy == 0 ? (with_req ? "R5 priority R8" : "R8 phy0 seq")
                                    : "R9 other phy seq");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ctl_word == 16'h0, "R1 ctl zero in reset", ctl_word, 0);
        chk({busy, done, err} == 3'b000, "R1 flags low in reset", {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_word == 16'h0 && !busy, "R1 idle after reset", ctl_word, 0);

        // sweep: phase length, PHY, length, data pattern
        for (int pc = 0; pc < 4; pc++) begin
            cfg_phase_cycles = 4'(pc);
            for (int ph = 0; ph < 3; ph++) begin
                for (int ln = 1; ln <= 8; ln++) begin
                    do_write(ph, 8'(8'hF8 + ln * 3 + ph), 8'(8'hA5 ^ (ln * 37 + ph * 11)),
                             ln, 1'b0);
                end
            end
        end

        cfg_phase_cycles = 4'd2;
        do_write(0, 8'h40, 8'b1011_0110, 6, 1'b1);
        do_write(2, 8'hFE, 8'h0F, 4, 1'b1);

        do_reject(1, 0, 1'b0, "R7 zero length");
        cfg_phy_count = 2'd2;
        do_reject(2, 3, 1'b0, "R7 phy beyond count");
        do_reject(2, 0, 1'b1, "R10 seq phy beyond count");
        do_write(1, 8'h33, 8'h5A, 7, 1'b0);
        cfg_phy_count = 2'd3;

        for (int th = 2; th <= 3; th++) begin
            cfg_disc_thresh = 2'(th);
            for (int pc = 1; pc <= 2; pc++) begin
                cfg_phase_cycles = 4'(pc);
                for (int ph = 0; ph < 3; ph++) do_seq(ph, 1'b0);
            end
        end
        do_seq(0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule